// File: doc/BRIEF.md
# Two-Clock Word Queue with Synchronized Status Flags

This block is a 64-entry, 36-bit first-in first-out queue. The queue sits between two unrelated clock domains. The producer side (port A) pushes words on its own clock. The consumer side (port B) pops words on a second, independent clock. Neither port uses a plain enable. Each port decodes an access from four pins: an active-low select, a direction bit, a side-channel select that must be low for queue traffic, and an enable.

Each domain carries a registered Gray-coded copy of its own pointer. That copy crosses to the other domain through two flip-flop stages. A flag therefore reacts at once to its own side's traffic. It reacts to the opposite side's traffic only after a short, bounded synchronizer delay.

Port A sees an active-low full indication. Port B sees an active-low empty indication and an active-low almost-empty indication. The almost-empty threshold is a build-time parameter, 8 words by default. Popped words appear in an output register, which holds its value between pops.

Top module: `dcfifo_top`

## Requirements
- R1: A push happens on a rising `a_clk` edge only when `a_sel_n`=0, `a_dir`=1, `a_side`=0, `a_en`=1 and `a_full_n`=1. Any other combination stores nothing.
- R2: A pop happens on a rising `b_clk` edge only when `b_sel_n`=0, `b_dir`=0, `b_side`=0, `b_en`=1 and `b_empty_n`=1. Any other combination removes nothing.
- R3: `b_data` is registered. It changes only on a pop, and it keeps the last popped word otherwise.
- R4: `a_full_n` is low from the port A edge on which the queue's 64th word is stored.
- R5: After a pop from a full queue, `a_full_n` returns high within four `a_clk` periods of the popping `b_clk` edge. The release lands on the second or third `a_clk` edge, depending on clock skew.
- R6: `b_aempty_n` is low whenever the queue holds AE_LEVEL (default 8) words or fewer. A pop that brings the count down to that level drives it low after that same port B edge.
- R7: After a push takes the count above AE_LEVEL, `b_aempty_n` returns high within four `b_clk` periods of the pushing `a_clk` edge.
- R8: A push attempted while `a_full_n` is low is discarded. No stored word changes, and the word order is unaffected.
- R9: A pop attempted while `b_empty_n` is low is discarded. `b_data` keeps its previous value.
- R10: `b_empty_n` is low whenever the queue holds no word. It returns high within four `b_clk` periods of the first push.
- R11: While `rst_n` is low, the queue is emptied and the outputs are `a_full_n`=1, `b_empty_n`=0, `b_aempty_n`=0 and `b_data`=0.
- R12: Words leave port B in exactly the order in which they were accepted at port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Producer clock |
| b_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| a_sel_n | input | 1 | Producer select, active low |
| a_dir | input | 1 | Producer direction, 1 selects a push |
| a_side | input | 1 | Producer side-channel select, must be 0 for queue access |
| a_en | input | 1 | Producer enable |
| a_data | input | 36 | Word to push |
| a_full_n | output | 1 | Queue full, active low, `a_clk` domain |
| b_sel_n | input | 1 | Consumer select, active low |
| b_dir | input | 1 | Consumer direction, 0 selects a pop |
| b_side | input | 1 | Consumer side-channel select, must be 0 for queue access |
| b_en | input | 1 | Consumer enable |
| b_data | output | 36 | Output register holding the last popped word |
| b_empty_n | output | 1 | Queue empty, active low, `b_clk` domain |
| b_aempty_n | output | 1 | At most AE_LEVEL words stored, active low, `b_clk` domain |

## Verification
The bench first fills the queue with more push attempts than there are entries. A design that wraps its write pointer would then overwrite the oldest word, and the pop stream would come out of order. It then drains past empty. A design that pops an empty queue would change `b_data` or shift the word order.

Decoy accesses are mixed into the traffic: a wrong direction, a raised side-channel select, or a deasserted select. A decoder that ignores any one of those pins accepts a word the reference queue does not hold.

Flag release is checked against a time window measured from the opposite port's edge. A flag that never releases, or one that releases before its own side has seen a pointer change, breaks either the immediate-assertion checks or the window checks.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        DIR_POP  = 1'b0,
        DIR_PUSH = 1'b1
    } port_dir_e;

    // Queue traffic needs select low, the side channel idle, enable high
    // and the direction matching the port's role.
    function automatic logic queue_access(input logic sel_n,
                                          input logic dir,
                                          input logic side,
                                          input logic en,
                                          input port_dir_e role);
        return !sel_n && !side && en && (dir == logic'(role));
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr #(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic [AW:0] rgray_sync,
    output logic        wr_fire,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        full_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_st_t;

    wr_st_t      st_d, st_q;
    logic [PW-1:0] full_pat;

    always_comb begin
        // Full when the write pointer is one lap ahead of the read pointer:
        // in Gray form, the two top bits are inverted and the rest are equal.
        full_pat = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
        full_n   = (st_q.gray != full_pat);
        wr_fire  = wr_req && full_n;
        st_d     = st_q;
        if (wr_fire) begin
            st_d.bin  = st_q.bin + ONE;
            st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wbin  = st_q.bin;
    assign wgray = st_q.gray;
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd #(
    parameter int AW       = 6,
    parameter int WIDTH    = 36,
    parameter int AE_LEVEL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [AW:0]      wgray_sync,
    input  logic [WIDTH-1:0] rd_word,
    output logic [AW:0]      rbin,
    output logic [AW:0]      rgray,
    output logic [WIDTH-1:0] data,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] ONE    = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] AE_LVL = PW'(AE_LEVEL);

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic [WIDTH-1:0] data;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] level;
    logic          rd_fire;

    always_comb begin
        // Gray to binary: each bit is the XOR of itself and all higher bits.
        wbin_s[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
        end
        level    = wbin_s - st_q.bin;
        empty_n  = (level != '0);
        aempty_n = (level > AE_LVL);
        rd_fire  = rd_req && empty_n;
        st_d     = st_q;
        if (rd_fire) begin
            st_d.data = rd_word;
            st_d.bin  = st_q.bin + ONE;
            st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rbin  = st_q.bin;
    assign rgray = st_q.gray;
    assign data  = st_q.data;
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top #(
    parameter int WIDTH    = 36,
    parameter int AW       = 6,
    parameter int AE_LEVEL = 8
) (
    input  logic             a_clk,
    input  logic             b_clk,
    input  logic             rst_n,
    input  logic             a_sel_n,
    input  logic             a_dir,
    input  logic             a_side,
    input  logic             a_en,
    input  logic [WIDTH-1:0] a_data,
    output logic             a_full_n,
    input  logic             b_sel_n,
    input  logic             b_dir,
    input  logic             b_side,
    input  logic             b_en,
    output logic [WIDTH-1:0] b_data,
    output logic             b_empty_n,
    output logic             b_aempty_n
);
    import dcfifo_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic             a_wr_req, a_wr_fire, b_rd_req;
    logic [AW:0]      wbin, wgray, rbin, rgray;
    logic [AW:0]      rgray_s, wgray_s;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_word;

    assign a_wr_req = queue_access(a_sel_n, a_dir, a_side, a_en, DIR_PUSH);
    assign b_rd_req = queue_access(b_sel_n, b_dir, b_side, b_en, DIR_POP);

    dcfifo_wr #(.AW(AW)) u_wr (
        .clk(a_clk), .rst_n(rst_n), .wr_req(a_wr_req), .rgray_sync(rgray_s),
        .wr_fire(a_wr_fire), .wbin(wbin), .wgray(wgray), .full_n(a_full_n)
    );

    dcfifo_sync #(.W(AW + 1)) u_r2w (
        .clk(a_clk), .rst_n(rst_n), .din(rgray), .dout(rgray_s)
    );

    dcfifo_sync #(.W(AW + 1)) u_w2r (
        .clk(b_clk), .rst_n(rst_n), .din(wgray), .dout(wgray_s)
    );

    always_ff @(posedge a_clk) begin
        if (a_wr_fire) mem[wbin[AW-1:0]] <= a_data;
    end

    assign rd_word = mem[rbin[AW-1:0]];

    dcfifo_rd #(.AW(AW), .WIDTH(WIDTH), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(b_clk), .rst_n(rst_n), .rd_req(b_rd_req), .wgray_sync(wgray_s),
        .rd_word(rd_word), .rbin(rbin), .rgray(rgray), .data(b_data),
        .empty_n(b_empty_n), .aempty_n(b_aempty_n)
    );
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
    parameter int WIDTH = 36,
    parameter int AW    = 6
) (
    input logic             a_clk,
    input logic             b_clk,
    input logic             rst_n,
    input logic             a_wr_req,
    input logic             b_rd_req,
    input logic             a_full_n,
    input logic             b_empty_n,
    input logic             b_aempty_n,
    input logic [AW:0]      wbin,
    input logic [AW:0]      rbin,
    input logic [AW:0]      rgray_s,
    input logic [WIDTH-1:0] b_data
);
    // R1: the write pointer advances by one step at most.
    p_wr_step_r1: assert property (@(posedge a_clk) disable iff (!rst_n)
        (wbin != $past(wbin)) |-> (wbin == $past(wbin) + 1'b1));

    // R8: a push attempt while full leaves the write pointer untouched.
    p_no_overflow_r8: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!a_full_n && a_wr_req) |=> $stable(wbin));

    // R9: a pop attempt while empty moves neither the read pointer nor the data.
    p_no_underflow_r9: assert property (@(posedge b_clk) disable iff (!rst_n)
        (!b_empty_n && b_rd_req) |=> ($stable(rbin) && $stable(b_data)));

    // R3: without a pop request the output register holds.
    p_hold_r3: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_rd_req |=> $stable(b_data));

    // R5: the synchronized read pointer changes by at most one bit per edge.
    p_gray_sync_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
        $countones(rgray_s ^ $past(rgray_s)) <= 1);

    // R6: an empty view is always also an almost-empty view.
    p_empty_in_ae_r6: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_empty_n |-> !b_aempty_n);
endmodule

bind dcfifo_top dcfifo_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n),
    .a_wr_req(a_wr_req), .b_rd_req(b_rd_req),
    .a_full_n(a_full_n), .b_empty_n(b_empty_n), .b_aempty_n(b_aempty_n),
    .wbin(wbin), .rbin(rbin), .rgray_s(rgray_s), .b_data(b_data)
);

// File: tb/dcfifo_top_tb.sv
`timescale 1ns/100ps
module dcfifo_top_tb;
    localparam real CLK_PERIOD = 10.0;
    localparam real B_PERIOD   = 13.0;
    localparam int  WIDTH      = 36;
    localparam int  DEPTH      = 64;
    localparam int  AE_LEVEL   = 8;

    logic a_clk = 0, b_clk = 0, rst_n = 0;
    logic a_sel_n = 1, a_dir = 0, a_side = 0, a_en = 0;
    logic [WIDTH-1:0] a_data = '0;
    logic b_sel_n = 1, b_dir = 0, b_side = 0, b_en = 0;
    logic a_full_n, b_empty_n, b_aempty_n;
    logic [WIDTH-1:0] b_data;

    always #(CLK_PERIOD/2) a_clk = ~a_clk;
    always #(B_PERIOD/2)   b_clk = ~b_clk;

    dcfifo_top #(.WIDTH(WIDTH), .AW(6), .AE_LEVEL(AE_LEVEL)) u_dut (
        .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_dir(a_dir), .a_side(a_side), .a_en(a_en),
        .a_data(a_data), .a_full_n(a_full_n),
        .b_sel_n(b_sel_n), .b_dir(b_dir), .b_side(b_side), .b_en(b_en),
        .b_data(b_data), .b_empty_n(b_empty_n), .b_aempty_n(b_aempty_n)
    );

    int compared = 0, mismatched = 0;
    logic [WIDTH-1:0] q[$];
    logic [WIDTH-1:0] exp_data = '0;
    logic push_pend = 0, pop_pend = 0;
    realtime last_wr_t = 0, last_rd_t = 0;
    int wr_pct = 0, rd_pct = 0;
    bit running = 0, done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference queue updates on the edges at which the design accepts.
    always @(posedge a_clk) if (push_pend) begin
        q.push_back(a_data);
        last_wr_t = $realtime;
    end
    always @(posedge b_clk) if (pop_pend) begin
        exp_data  = q.pop_front();
        last_rd_t = $realtime;
    end

    // Port A: checks, then drive for the next edge.
    initial begin
        wait (running);
        forever begin
            @(negedge a_clk);
            if (done) break;
            if (q.size() == DEPTH)
                chk(a_full_n == 0, "R4", "full_n with 64 words", a_full_n, 0);
            if (!a_full_n && q.size() < DEPTH)
                chk(($realtime - last_rd_t) <= 4*CLK_PERIOD, "R5", "full_n release late",
                    q.size(), DEPTH);
            a_sel_n = 0; a_dir = 1; a_side = 0;
            a_en = ($urandom_range(99) < wr_pct);
            a_data = {$urandom, 4'($urandom)};
            case ($urandom_range(19))
                0: a_sel_n = 1;
                1: a_dir   = 0;
                2: a_side  = 1;
                default: ;
            endcase
            // R1 / R8: the model stores only a fully decoded push while not full.
            push_pend = !a_sel_n && a_dir && !a_side && a_en && a_full_n;
        end
        push_pend = 0; a_en = 0;
    end

    // Port B: compare every clock, then drive.
    initial begin
        wait (running);
        forever begin
            @(negedge b_clk);
            if (done) break;
            // R3 / R9 / R12: output register equals the last word the model popped.
            chk(b_data == exp_data, "R12", "b_data order/hold", b_data, exp_data);
            if (q.size() <= AE_LEVEL)
                chk(b_aempty_n == 0, "R6", "aempty_n at low level", b_aempty_n, 0);
            if (!b_aempty_n && q.size() > AE_LEVEL)
                chk(($realtime - last_wr_t) <= 4*B_PERIOD, "R7", "aempty_n release late",
                    q.size(), AE_LEVEL);
            if (q.size() == 0)
                chk(b_empty_n == 0, "R10", "empty_n with no word", b_empty_n, 0);
            if (!b_empty_n && q.size() > 0)
                chk(($realtime - last_wr_t) <= 4*B_PERIOD, "R10", "empty_n release late",
                    q.size(), 0);
            b_sel_n = 0; b_dir = 0; b_side = 0;
            b_en = ($urandom_range(99) < rd_pct);
            case ($urandom_range(19))
                0: b_sel_n = 1;
                1: b_dir   = 1;
                2: b_side  = 1;
                default: ;
            endcase
            // R2 / R9: the model pops only a fully decoded pop while not empty.
            pop_pend = !b_sel_n && !b_dir && !b_side && b_en && b_empty_n;
        end
        pop_pend = 0; b_en = 0;
    end

    initial begin
        fork
            begin
                #(200000 * CLK_PERIOD);
                chk(0, "WD", "watchdog expired", 0, 1);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        join_none
        #(3*CLK_PERIOD);
        // R11: reset state.
        chk(a_full_n == 1, "R11", "reset full_n", a_full_n, 1);
        chk(b_empty_n == 0, "R11", "reset empty_n", b_empty_n, 0);
        chk(b_aempty_n == 0, "R11", "reset aempty_n", b_aempty_n, 0);
        chk(b_data == 0, "R11", "reset b_data", b_data, 0);
        @(negedge a_clk); rst_n = 1;
        repeat (2) @(negedge a_clk);
        running = 1;
        // Fill past full (R4, R8), then drain past empty (R9, R5).
        wr_pct = 100; rd_pct = 0;   #(120*CLK_PERIOD);
        wr_pct = 0;   rd_pct = 100; #(120*B_PERIOD);
        // Mixed traffic around both thresholds.
        wr_pct = 30;  rd_pct = 70;  #(800*CLK_PERIOD);
        wr_pct = 70;  rd_pct = 30;  #(800*CLK_PERIOD);
        wr_pct = 90;  rd_pct = 85;  #(800*CLK_PERIOD);
        wr_pct = 0;   rd_pct = 100; #(150*B_PERIOD);
        done = 1;
        #(3*B_PERIOD);
        chk(q.size() == 0, "R12", "model drained", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule